// File: doc/BRIEF.md
# Field-Masked Alarm Comparator

This block watches a running BCD clock and calendar and decides, once per second, whether the current time matches a programmed alarm. Six alarm registers, one each for second, minute, hour, date, month and day of week, each carry a compare-enable bit and a BCD match value. A field whose enable is clear is ignored. This allows partial alarms such as "every day at 07:30:00" or "every minute at second 15".

A match sets a sticky status flag. A global enable decides whether the match also drives the interrupt line. A mode input selects the interrupt style. In level mode the line follows the flag until software clears it. In pulse mode each match produces a fixed-width pulse, and the line returns low without software help. The live fields, alarm registers and control inputs are plain level signals that the surrounding clock core and register file hold. The only event input is the one-cycle seconds tick. There is no streaming data path, so no valid/ready handshake is used.

Top module: `alm_compare_top`

## Requirements
- R1: After reset, `alm_flag` and `alm_irq` are both 0.
- R2: `cur_fields` and `alarm_regs` are each six 8-bit fields. Field i occupies bits [8i+7:8i] in the order second (i=0), minute, hour, date, month, day of week (i=5). Bit 7 of an alarm field enables that field. Bits 6:0 of an enabled field must equal bits 6:0 of the live field for that field to match.
- R3: If no alarm field has its enable bit set, no match ever occurs.
- R4: A field whose enable bit is clear is ignored, whatever its value. A match needs every enabled field to be equal.
- R5: A match is evaluated only on a clock edge where `sec_tick` is 1. An equal time with `sec_tick` low leaves the flag unchanged.
- R6: A match sets `alm_flag` on the edge that samples `sec_tick`. The flag then stays 1 until it is cleared.
- R7: `flag_clr` high at an edge clears `alm_flag`. If a match is sampled at the same edge, the flag is set instead.
- R8: With `pulse_mode` 0, `alm_irq` equals `alm_flag` AND `alm_en` at all times.
- R9: With `pulse_mode` 1, a match sampled while `alm_en` is 1 drives `alm_irq` high for exactly `PULSE_W` cycles, starting at that edge. A new match restarts the pulse.
- R10: With `alm_en` 0, a match still sets `alm_flag` but does not raise `alm_irq` in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| cur_fields | input | 48 | Live BCD second, minute, hour, date, month, day of week |
| alarm_regs | input | 48 | Alarm fields; bit 7 of each is its compare enable |
| alm_en | input | 1 | Global alarm interrupt enable |
| pulse_mode | input | 1 | 0 = level interrupt until cleared, 1 = fixed-width pulse |
| flag_clr | input | 1 | Clears the alarm flag |
| alm_flag | output | 1 | Sticky alarm status flag |
| alm_irq | output | 1 | Alarm interrupt line, active high |

## Verification
The flag and the pulse-mode interrupt both change on the rising edge that samples `sec_tick`. The level-mode interrupt follows the flag and `alm_en` with no extra register. The bench drives every input on the falling edge, holds the tick for one rising edge, and reads the results on the next falling edge. In pulse mode it samples `alm_irq` on each of the following falling edges and expects it high for the first `PULSE_W` samples and low after that. A change to `alm_en` alone is checked one time step after it is driven, with no edge in between.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam int VAL_W      = FIELD_W - 1;
  localparam int BUS_W      = FIELD_W * NUM_FIELDS;

  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_PULSE = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int FW = 8
) (
  input  logic [FW-1:0] live_val,
  input  logic [FW-1:0] alarm_val,
  output logic          cmp_en,
  output logic          cmp_eq
);
  localparam int VW = FW - 1;

  // top bit of the alarm field arms the comparison, the rest is the value
  assign cmp_en = alarm_val[FW-1];
  assign cmp_eq = (live_val[VW-1:0] == alarm_val[VW-1:0]);
endmodule

// File: rtl/alm_match_eval.sv
module alm_match_eval
  import alm_pkg::*;
#(
  parameter int N  = NUM_FIELDS,
  parameter int FW = FIELD_W
) (
  input  logic [N*FW-1:0] live_bus,
  input  logic [N*FW-1:0] alarm_bus,
  output logic [N-1:0]    en_mask,
  output logic            hit
);
  logic [N-1:0] eq_mask;

  for (genvar g = 0; g < N; g++) begin : g_field
    alm_field_cmp #(.FW(FW)) u_cmp (
      .live_val  (live_bus[g*FW +: FW]),
      .alarm_val (alarm_bus[g*FW +: FW]),
      .cmp_en    (en_mask[g]),
      .cmp_eq    (eq_mask[g])
    );
  end

  // a disabled field counts as satisfied, but at least one must be armed
  assign hit = (|en_mask) && (&(eq_mask | ~en_mask));
endmodule

// File: rtl/alm_irq_gen.sv
module alm_irq_gen
  import alm_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic hit,
  input  logic alm_en,
  input  logic pulse_mode,
  input  logic flag_clr,
  output logic alm_flag,
  output logic alm_irq
);
  localparam int CNT_W = $clog2(PULSE_W + 1);

  irq_mode_e   mode;
  logic        fire;
  logic        load;
  logic [CNT_W-1:0] cnt;

  assign mode = irq_mode_e'(pulse_mode);
  assign fire = sec_tick && hit;
  assign load = fire && alm_en && (mode == IRQ_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alm_flag <= 1'b0;
    else if (fire)     alm_flag <= 1'b1;
    else if (flag_clr) alm_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CNT_W'(PULSE_W);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  always_comb begin
    if (mode == IRQ_PULSE) alm_irq = (cnt != '0);
    else                   alm_irq = alm_flag && alm_en;
  end

  AST_FLAG_SET_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> alm_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !flag_clr) |=> alm_flag); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fire) |=> !alm_flag); // R7
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alm_flag) |=> !alm_flag); // R5
  AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) && !load) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R9
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PULSE_W)); // R9
endmodule

// File: rtl/alm_compare_top.sv
module alm_compare_top
  import alm_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [BUS_W-1:0] cur_fields,
  input  logic [BUS_W-1:0] alarm_regs,
  input  logic             alm_en,
  input  logic             pulse_mode,
  input  logic             flag_clr,
  output logic             alm_flag,
  output logic             alm_irq
);
  logic [NUM_FIELDS-1:0] en_mask;
  logic                  hit;

  alm_match_eval #(.N(NUM_FIELDS), .FW(FIELD_W)) u_eval (
    .live_bus  (cur_fields),
    .alarm_bus (alarm_regs),
    .en_mask   (en_mask),
    .hit       (hit)
  );

  alm_irq_gen #(.PULSE_W(PULSE_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .hit        (hit),
    .alm_en     (alm_en),
    .pulse_mode (pulse_mode),
    .flag_clr   (flag_clr),
    .alm_flag   (alm_flag),
    .alm_irq    (alm_irq)
  );

  AST_NONE_ARMED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0) |-> !hit); // R3
  AST_DISABLED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && !alm_en) |-> !alm_irq); // R10
  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !alm_irq && !(sec_tick && alm_en)) |=> !alm_irq); // R9
endmodule

// File: tb/alm_compare_top_test.sv
module alm_compare_top_test;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [47:0] cur_fields = '0;
  logic [47:0] alarm_regs = '0;
  logic        alm_en = 1'b0;
  logic        pulse_mode = 1'b0;
  logic        flag_clr = 1'b0;
  logic        alm_flag;
  logic        alm_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] live [6] = '{8'h45, 8'h30, 8'h12, 8'h25, 8'h09, 8'h03};

  always #2 clk = ~clk;

  alm_compare_top #(.PULSE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_fields(cur_fields), .alarm_regs(alarm_regs),
    .alm_en(alm_en), .pulse_mode(pulse_mode), .flag_clr(flag_clr),
    .alm_flag(alm_flag), .alm_irq(alm_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic do_clear();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // arm fields in mask m; fields in d differ in bit 0
  task automatic set_alarm(input logic [5:0] m, input logic [5:0] d);
    for (int f = 0; f < 6; f++) begin
      alarm_regs[f*8 +: 8] = {m[f], live[f][6:0] ^ {6'b0, d[f]}};
    end
  endtask

  initial begin
    for (int f = 0; f < 6; f++) cur_fields[f*8 +: 8] = live[f];
    @(negedge clk);
    @(negedge clk);
    check("R1 flag", alm_flag, 1'b0);
    check("R1 irq", alm_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after release", alm_flag, 1'b0);

    // sweep all enable masks against all mismatch patterns, level mode
    alm_en = 1'b1;
    for (int m = 0; m < 64; m++) begin
      for (int d = 0; d < 64; d++) begin
        logic exp;
        set_alarm(6'(m), 6'(d));
        do_clear();
        do_tick();
        exp = (m != 0) && ((m & d) == 0);
        check(m == 0 ? "R3 none armed" : "R2/R4 masked match", alm_flag, exp);
        check("R8 level irq", alm_irq, exp);
      end
    end

    // R5: equal time without a tick leaves flag clear
    set_alarm(6'h3F, 6'h00);
    do_clear();
    repeat (5) @(negedge clk);
    check("R5 no tick no set", alm_flag, 1'b0);

    // R6: flag holds without clear
    do_tick();
    set_alarm(6'h3F, 6'h3F);
    repeat (4) @(negedge clk);
    check("R6 flag sticky", alm_flag, 1'b1);
    check("R8 irq follows flag", alm_irq, 1'b1);

    // R7: clear then simultaneous set-and-clear
    do_clear();
    check("R7 clear", alm_flag, 1'b0);
    check("R8 irq drops with flag", alm_irq, 1'b0);
    set_alarm(6'h01, 6'h00);
    flag_clr = 1'b1;
    do_tick();
    flag_clr = 1'b0;
    check("R7 set wins over clear", alm_flag, 1'b1);

    // R10 / R8: global enable off
    do_clear();
    alm_en = 1'b0;
    do_tick();
    check("R10 flag still sets", alm_flag, 1'b1);
    check("R10 no irq", alm_irq, 1'b0);
    alm_en = 1'b1;
    #1;
    check("R8 irq on enable", alm_irq, 1'b1);
    @(negedge clk);

    // R9: pulse width
    pulse_mode = 1'b1;
    do_clear();
    check("R9 idle pulse low", alm_irq, 1'b0);
    do_tick();
    check("R9 flag in pulse mode", alm_flag, 1'b1);
    for (int i = 0; i < PW + 3; i++) begin
      check("R9 pulse shape", alm_irq, (i < PW));
      @(negedge clk);
    end
    check("R9 flag stays after pulse", alm_flag, 1'b1);

    // R9: retrigger mid-pulse restarts width
    do_tick();
    @(negedge clk);
    do_tick();
    for (int i = 0; i < PW + 2; i++) begin
      check("R9 retrigger", alm_irq, (i < PW));
      @(negedge clk);
    end

    // R10: pulse mode with enable off
    alm_en = 1'b0;
    do_clear();
    do_tick();
    for (int i = 0; i < PW; i++) begin
      check("R10 no pulse", alm_irq, 1'b0);
      @(negedge clk);
    end
    check("R10 flag set in pulse mode", alm_flag, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule